// File: doc/BRIEF.md
# Serial Flash Status Register Controller

This block holds the first status byte of a serial NOR flash device and decides, one instruction at a time, whether each decoded instruction is taken or dropped. An SPI front end presents single-cycle instruction strobes: latch enable, latch disable, status read, status write (with its data byte), program, erase, security-area operation, suspend/resume and soft reset. The block answers in the same cycle with an accept or reject flag. Any state change takes effect on the clock edge that closes that cycle.

Program, erase, security-area and status-write instructions start a busy period. Its length in clock cycles is a parameter for each operation class. While the period runs, only status reads and suspend/resume strobes get through. The write enable latch must be set before any modifying instruction is accepted, and accepting such an instruction clears the latch again. The six protection bits (bits 7 to 2) can be changed only by an accepted status write. They survive a soft reset but are cleared by the power-on reset `rst_n`.

Top module: `flash_sr_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the status byte becomes 0x00. This clears the protection bits, the write enable latch, busy and any suspension.
- R2: Status layout, MSB first: bit 7 write-protect lock, bit 6 sector/block select, bit 5 top/bottom select, bits 4..2 block-protect field, bit 1 write enable latch, bit 0 busy. An accepted status write copies `wr_data[7:2]` into bits 7..2. Bits 1..0 ignore the written data.
- R3: An accepted program, erase, security-area or status-write instruction sets busy on its accept edge. Busy then reads 1 for exactly T cycles, where T is that class's duration parameter, and returns to 0 on the T-th following edge.
- R4: While busy is 1, every instruction is rejected except status read and suspend.
- R5: An accepted latch-enable instruction sets bit 1 on its accept edge.
- R6: Bit 1 is cleared on the accept edge of latch disable, program, erase, security-area operation, status write and soft reset.
- R7: Program, erase, security-area and status-write instructions are rejected while bit 1 is 0. A rejected instruction does not start busy.
- R8: A status write is rejected when bit 7 is 1 and `wp_n` is low. A rejected instruction changes no status bit.
- R9: An accepted soft reset clears bit 1, keeps bits 7..2, and is rejected while busy.
- R10: Suspend is rejected when not busy. The first accepted suspend freezes the busy countdown, with busy held at 1. The next accepted suspend resumes the countdown from where it stopped.
- R11: A cycle in which more than one strobe is high rejects all of them and changes nothing.
- R12: Status read is accepted in every state, changes nothing, and `status` always shows the current register value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| cmd_wren | input | 1 | Latch-enable strobe |
| cmd_wrdi | input | 1 | Latch-disable strobe |
| cmd_rdsr | input | 1 | Status-read strobe |
| cmd_wrsr | input | 1 | Status-write strobe |
| cmd_prog | input | 1 | Page program strobe (single or quad) |
| cmd_erase | input | 1 | Sector, block or chip erase strobe |
| cmd_secop | input | 1 | Security-area erase/program strobe |
| cmd_suspend | input | 1 | Suspend/resume toggle strobe |
| cmd_softrst | input | 1 | Soft reset strobe |
| wr_data | input | 8 | Data byte for the status write |
| wp_n | input | 1 | Write-protect pin, active low |
| status | output | 8 | Current status byte |
| cmd_accept | output | 1 | The strobe presented this cycle is taken |
| cmd_reject | output | 1 | A strobe is presented this cycle and dropped |

## Verification
Two functions can meet in the same cycle: the busy countdown reaching zero and a new instruction arriving. The bench presents a latch-enable strobe in the last busy cycle of both a status write and a resumed erase. It expects a reject and an unchanged latch, because the gate judges the instruction against busy as it stood before that edge. A second collision is a suspend strobe arriving in the cycle right after an erase is accepted. The bench judges this by checking that busy persists beyond the erase duration and then ends exactly the remaining number of cycles after the resume.

// File: rtl/flash_sr_pkg.sv
// Package: shared types for the flash status register controller.
// Assumes at most a handful of operation classes; durations are counted in clock cycles.
package flash_sr_pkg;

    // One decoded instruction per field; all fields zero means no instruction.
    typedef struct packed {
        logic wren;
        logic wrdi;
        logic rdsr;
        logic wrsr;
        logic prog;
        logic erase;
        logic secop;
        logic susp;
        logic srst;
    } fsr_cmd_t;

    localparam int CMD_BITS = $bits(fsr_cmd_t);

    // Larger of two durations, used to size the busy counter.
    function automatic int fsr_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/fsr_gate.sv
// Module: fsr_gate
// Decides acceptance of the instruction presented this cycle from the current
// busy flag, write enable latch, lock bit and write-protect pin.
// Purely combinational; assumes state inputs come straight from registers.
module fsr_gate
    import flash_sr_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  fsr_cmd_t cmd,
    input  logic     busy,
    input  logic     wel,
    input  logic     lock,
    input  logic     wp_n,
    output fsr_cmd_t acc,
    output logic     accept,
    output logic     reject
);
    logic [$clog2(CMD_BITS+1)-1:0] n_strobes;
    logic                           single;
    logic                           idle_ok;
    logic                           mod_ok;
    logic                           wrsr_ok;

    // Count raised strobes and derive the per-class permission terms.
    always_comb begin
        n_strobes = '0;
        for (int i = 0; i < CMD_BITS; i++) begin
            n_strobes = n_strobes + {{($bits(n_strobes)-1){1'b0}}, cmd[i]};
        end
        single  = (n_strobes == 1);
        idle_ok = single && !busy;
        mod_ok  = idle_ok && wel;
        wrsr_ok = mod_ok && (!lock || wp_n);
    end

    // Qualify each strobe with its permission.
    always_comb begin
        acc       = '0;
        acc.rdsr  = cmd.rdsr  && single;
        acc.susp  = cmd.susp  && single && busy;
        acc.wren  = cmd.wren  && idle_ok;
        acc.wrdi  = cmd.wrdi  && idle_ok;
        acc.srst  = cmd.srst  && idle_ok;
        acc.prog  = cmd.prog  && mod_ok;
        acc.erase = cmd.erase && mod_ok;
        acc.secop = cmd.secop && mod_ok;
        acc.wrsr  = cmd.wrsr  && wrsr_ok;
        accept    = |acc;
        reject    = (n_strobes != 0) && !accept;
    end

    a_r4_busy_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && accept) |-> (cmd.rdsr || cmd.susp));
    a_r7_need_wel: assert property (@(posedge clk) disable iff (!rst_n)
        (!wel && (cmd.prog || cmd.erase || cmd.secop || cmd.wrsr)) |-> !accept);
    a_r8_lock_pin: assert property (@(posedge clk) disable iff (!rst_n)
        (lock && !wp_n && cmd.wrsr) |-> !accept);
    a_r11_multi: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(cmd) > 1) |-> (!accept && reject));
    a_r12_read_ok: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(cmd) == 1 && cmd.rdsr) |-> accept);
endmodule

// File: rtl/fsr_busy_timer.sv
// Module: fsr_busy_timer
// Models the busy period of modifying operations with a down-counter loaded
// from a per-class duration, and a suspend toggle that freezes the count.
// Assumes every duration is at least 1 and only one load per cycle (gate-enforced).
module fsr_busy_timer
    import flash_sr_pkg::*;
#(
    parameter int T_PROG  = 5,
    parameter int T_ERASE = 7,
    parameter int T_WRSR  = 3,
    parameter int T_SEC   = 4
) (
    input  logic     clk,
    input  logic     rst_n,
    input  fsr_cmd_t acc,
    output logic     busy
);
    localparam int T_MAX = fsr_max(fsr_max(T_PROG, T_ERASE), fsr_max(T_WRSR, T_SEC));
    localparam int CW    = $clog2(T_MAX + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] load_val;
    logic          load;
    logic          susp_q;
    logic          susp_nx;

    // Select the duration of the accepted operation and the next suspend state.
    always_comb begin
        load     = 1'b1;
        load_val = '0;
        if (acc.prog)       load_val = CW'(T_PROG);
        else if (acc.erase) load_val = CW'(T_ERASE);
        else if (acc.wrsr)  load_val = CW'(T_WRSR);
        else if (acc.secop) load_val = CW'(T_SEC);
        else                load = 1'b0;
        susp_nx = susp_q ^ acc.susp;
    end

    // Count down unless suspended; load on an accepted busy-causing instruction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            susp_q <= 1'b0;
        end else begin
            susp_q <= susp_nx;
            if (load)
                cnt <= load_val;
            else if (cnt != 0 && !susp_nx)
                cnt <= cnt - 1'b1;
        end
    end

    assign busy = (cnt != 0);

    a_r10_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (susp_q && !acc.susp) |=> $stable(cnt));
    a_r3_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !susp_q && !acc.susp) |=> (cnt == $past(cnt) - 1'b1));
    a_r3_start: assert property (@(posedge clk) disable iff (!rst_n)
        (acc.prog || acc.erase || acc.wrsr || acc.secop) |=> busy);
    a_r10_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !susp_q);
endmodule

// File: rtl/fsr_regs.sv
// Module: fsr_regs
// Holds the six protection bits and the write enable latch.
// Protection bits change only on an accepted status write and persist across
// soft reset; rst_n models power-on and returns them to the unprotected default.
module fsr_regs
    import flash_sr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  fsr_cmd_t   acc,
    input  logic [7:0] wr_data,
    output logic [5:0] prot,
    output logic       wel
);
    logic wel_clr;

    // Instructions that drop the latch when accepted.
    always_comb begin
        wel_clr = acc.wrdi || acc.prog || acc.erase || acc.secop || acc.wrsr || acc.srst;
    end

    // Protection bits: load bits 7..2 of the write data on an accepted status write.
    always_ff @(posedge clk) begin
        if (!rst_n)        prot <= '0;
        else if (acc.wrsr) prot <= wr_data[7:2];
    end

    // Write enable latch: set by latch enable, cleared by modifying instructions.
    always_ff @(posedge clk) begin
        if (!rst_n)       wel <= 1'b0;
        else if (acc.wren) wel <= 1'b1;
        else if (wel_clr)  wel <= 1'b0;
    end

    a_r5_wel_set: assert property (@(posedge clk) disable iff (!rst_n)
        acc.wren |=> wel);
    a_r6_wel_clear: assert property (@(posedge clk) disable iff (!rst_n)
        wel_clr |=> !wel);
    a_r2_prot_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !acc.wrsr |=> $stable(prot));
    a_r9_srst_keep: assert property (@(posedge clk) disable iff (!rst_n)
        acc.srst |=> $stable(prot));
endmodule

// File: rtl/flash_sr_ctrl.sv
// Module: flash_sr_ctrl (top)
// Status register controller for a serial NOR flash: gates decoded
// instructions, sequences the write enable latch and busy period, and
// presents the status byte. Assumes strobes are single-cycle and decoded upstream.
module flash_sr_ctrl
    import flash_sr_pkg::*;
#(
    parameter int T_PROG  = 5,
    parameter int T_ERASE = 7,
    parameter int T_WRSR  = 3,
    parameter int T_SEC   = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_wren,
    input  logic       cmd_wrdi,
    input  logic       cmd_rdsr,
    input  logic       cmd_wrsr,
    input  logic       cmd_prog,
    input  logic       cmd_erase,
    input  logic       cmd_secop,
    input  logic       cmd_suspend,
    input  logic       cmd_softrst,
    input  logic [7:0] wr_data,
    input  logic       wp_n,
    output logic [7:0] status,
    output logic       cmd_accept,
    output logic       cmd_reject
);
    fsr_cmd_t   cmd;
    fsr_cmd_t   acc;
    logic       busy;
    logic       wel;
    logic [5:0] prot;

    // Bundle the strobes into one command word.
    always_comb begin
        cmd.wren  = cmd_wren;
        cmd.wrdi  = cmd_wrdi;
        cmd.rdsr  = cmd_rdsr;
        cmd.wrsr  = cmd_wrsr;
        cmd.prog  = cmd_prog;
        cmd.erase = cmd_erase;
        cmd.secop = cmd_secop;
        cmd.susp  = cmd_suspend;
        cmd.srst  = cmd_softrst;
    end

    fsr_gate u_gate (
        .clk    (clk),
        .rst_n  (rst_n),
        .cmd    (cmd),
        .busy   (busy),
        .wel    (wel),
        .lock   (prot[5]),
        .wp_n   (wp_n),
        .acc    (acc),
        .accept (cmd_accept),
        .reject (cmd_reject)
    );

    fsr_busy_timer #(
        .T_PROG  (T_PROG),
        .T_ERASE (T_ERASE),
        .T_WRSR  (T_WRSR),
        .T_SEC   (T_SEC)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .acc   (acc),
        .busy  (busy)
    );

    fsr_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .acc     (acc),
        .wr_data (wr_data),
        .prot    (prot),
        .wel     (wel)
    );

    assign status = {prot, wel, busy};

    a_r1_reset: assert property (@(posedge clk)
        !rst_n |=> (status == 8'h00));
    a_r11_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_reject |=> $stable(status[7:1]));
endmodule

// File: tb/flash_sr_ctrl_tb.sv
// Bench for flash_sr_ctrl: a vector table walked by one loop, then directed
// checks for reset, simultaneous strobes and power-on clearing of protection.
module flash_sr_ctrl_tb_top;
    // Op codes used by the vector table.
    localparam logic [3:0] OP_NONE = 4'd0, OP_WREN = 4'd1, OP_WRDI = 4'd2,
                           OP_RDSR = 4'd3, OP_WRSR = 4'd4, OP_PROG = 4'd5,
                           OP_ERAS = 4'd6, OP_SEC  = 4'd7, OP_SUSP = 4'd8,
                           OP_SRST = 4'd9;
    localparam int NV = 48;
    // {op, data, wp_n, expected accept, expected status after the edge}
    localparam logic [21:0] VEC [NV] = '{
        {OP_WREN, 8'h00, 1'b1, 1'b1, 8'h02},  // 0  R5
        {OP_WRSR, 8'h5F, 1'b1, 1'b1, 8'h5D},  // 1  R2 R3 R6
        {OP_RDSR, 8'h00, 1'b1, 1'b1, 8'h5D},  // 2  R12
        {OP_NONE, 8'h00, 1'b1, 1'b0, 8'h5D},  // 3
        {OP_WREN, 8'h00, 1'b1, 1'b0, 8'h5C},  // 4  R4 last busy cycle
        {OP_PROG, 8'h00, 1'b1, 1'b0, 8'h5C},  // 5  R7
        {OP_WREN, 8'h00, 1'b1, 1'b1, 8'h5E},  // 6
        {OP_ERAS, 8'h00, 1'b1, 1'b1, 8'h5D},  // 7  R3
        {OP_SUSP, 8'h00, 1'b1, 1'b1, 8'h5D},  // 8  R10 freeze
        {OP_NONE, 8'h00, 1'b1, 1'b0, 8'h5D},  // 9
        {OP_NONE, 8'h00, 1'b1, 1'b0, 8'h5D},  // 10
        {OP_SUSP, 8'h00, 1'b1, 1'b1, 8'h5D},  // 11 R10 resume
        {OP_PROG, 8'h00, 1'b1, 1'b0, 8'h5D},  // 12 R4
        {OP_WRDI, 8'h00, 1'b1, 1'b0, 8'h5D},  // 13 R4
        {OP_SRST, 8'h00, 1'b1, 1'b0, 8'h5D},  // 14 R9
        {OP_RDSR, 8'h00, 1'b1, 1'b1, 8'h5D},  // 15 R12
        {OP_NONE, 8'h00, 1'b1, 1'b0, 8'h5D},  // 16
        {OP_WREN, 8'h00, 1'b1, 1'b0, 8'h5C},  // 17 R4 last busy cycle
        {OP_SUSP, 8'h00, 1'b1, 1'b0, 8'h5C},  // 18 R10 idle
        {OP_WREN, 8'h00, 1'b1, 1'b1, 8'h5E},  // 19
        {OP_SRST, 8'h00, 1'b1, 1'b1, 8'h5C},  // 20 R9
        {OP_WREN, 8'h00, 1'b1, 1'b1, 8'h5E},  // 21
        {OP_WRDI, 8'h00, 1'b1, 1'b1, 8'h5C},  // 22 R6
        {OP_WREN, 8'h00, 1'b1, 1'b1, 8'h5E},  // 23
        {OP_WRSR, 8'h80, 1'b0, 1'b1, 8'h81},  // 24 R8 lock clear, pin low
        {OP_NONE, 8'h00, 1'b1, 1'b0, 8'h81},  // 25
        {OP_NONE, 8'h00, 1'b1, 1'b0, 8'h81},  // 26
        {OP_RDSR, 8'h00, 1'b1, 1'b1, 8'h80},  // 27
        {OP_WREN, 8'h00, 1'b1, 1'b1, 8'h82},  // 28
        {OP_WRSR, 8'h00, 1'b0, 1'b0, 8'h82},  // 29 R8 locked
        {OP_WRSR, 8'h04, 1'b1, 1'b1, 8'h05},  // 30 R8 pin high
        {OP_NONE, 8'h00, 1'b1, 1'b0, 8'h05},  // 31
        {OP_NONE, 8'h00, 1'b1, 1'b0, 8'h05},  // 32
        {OP_NONE, 8'h00, 1'b1, 1'b0, 8'h04},  // 33 R3
        {OP_WREN, 8'h00, 1'b1, 1'b1, 8'h06},  // 34
        {OP_SEC,  8'h00, 1'b1, 1'b1, 8'h05},  // 35 R3 R6
        {OP_NONE, 8'h00, 1'b1, 1'b0, 8'h05},  // 36
        {OP_NONE, 8'h00, 1'b1, 1'b0, 8'h05},  // 37
        {OP_NONE, 8'h00, 1'b1, 1'b0, 8'h05},  // 38
        {OP_NONE, 8'h00, 1'b1, 1'b0, 8'h04},  // 39 R3
        {OP_WREN, 8'h00, 1'b1, 1'b1, 8'h06},  // 40
        {OP_PROG, 8'h00, 1'b1, 1'b1, 8'h05},  // 41 R3 R6
        {OP_NONE, 8'h00, 1'b1, 1'b0, 8'h05},  // 42
        {OP_NONE, 8'h00, 1'b1, 1'b0, 8'h05},  // 43
        {OP_NONE, 8'h00, 1'b1, 1'b0, 8'h05},  // 44
        {OP_NONE, 8'h00, 1'b1, 1'b0, 8'h05},  // 45
        {OP_NONE, 8'h00, 1'b1, 1'b0, 8'h04},  // 46 R3
        {OP_ERAS, 8'h00, 1'b1, 1'b0, 8'h04}   // 47 R7
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       c_wren = 0, c_wrdi = 0, c_rdsr = 0, c_wrsr = 0, c_prog = 0;
    logic       c_erase = 0, c_sec = 0, c_susp = 0, c_srst = 0;
    logic [7:0] wr_data = 8'h00;
    logic       wp_n = 1'b1;
    logic [7:0] status;
    logic       cmd_accept, cmd_reject;
    int         n_run = 0, n_fail = 0;

    always #2 clk = ~clk;

    flash_sr_ctrl dut_i (
        .clk(clk), .rst_n(rst_n),
        .cmd_wren(c_wren), .cmd_wrdi(c_wrdi), .cmd_rdsr(c_rdsr), .cmd_wrsr(c_wrsr),
        .cmd_prog(c_prog), .cmd_erase(c_erase), .cmd_secop(c_sec),
        .cmd_suspend(c_susp), .cmd_softrst(c_srst),
        .wr_data(wr_data), .wp_n(wp_n),
        .status(status), .cmd_accept(cmd_accept), .cmd_reject(cmd_reject)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [3:0] op);
        c_wren  = (op == OP_WREN);
        c_wrdi  = (op == OP_WRDI);
        c_rdsr  = (op == OP_RDSR);
        c_wrsr  = (op == OP_WRSR);
        c_prog  = (op == OP_PROG);
        c_erase = (op == OP_ERAS);
        c_sec   = (op == OP_SEC);
        c_susp  = (op == OP_SUSP);
        c_srst  = (op == OP_SRST);
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        #(4 * 200000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset status", status, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            logic [3:0] op;
            logic [7:0] st;
            logic       ea;
            op = VEC[i][21:18];
            ea = VEC[i][8];
            st = VEC[i][7:0];
            @(negedge clk);
            drive(op);
            wr_data = VEC[i][17:10];
            wp_n    = VEC[i][9];
            #1;
            chk($sformatf("R4/R7/R8 accept vec %0d", i), {7'd0, cmd_accept}, {7'd0, ea});
            chk($sformatf("R11 reject vec %0d", i), {7'd0, cmd_reject},
                {7'd0, (op != OP_NONE) && !ea});
            @(posedge clk);
            #1;
            chk($sformatf("R2/R3/R5/R6/R9/R10/R12 status vec %0d", i), status, st);
        end

        // R11: two strobes together are both dropped, latch stays 0.
        @(negedge clk);
        drive(OP_NONE);
        c_wren = 1'b1;
        c_rdsr = 1'b1;
        #1;
        chk("R11 multi accept", {7'd0, cmd_accept}, 8'd0);
        @(posedge clk);
        #1;
        chk("R11 multi status", status, 8'h04);

        // R9 and R1: power-on reset clears protection that soft reset keeps.
        @(negedge clk);
        drive(OP_NONE);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        chk("R1 power-on clears protection", status, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        chk("R1 idle after reset", status, 8'h00);
        finish_run();
    end
endmodule